// File: doc/BRIEF.md
# Dispatch Stall Controller with Skid Buffer

This block is the dispatch-stage controller for one hardware thread. It sits between the rename stage and the issue and load-store queues. Each cycle it receives a group of up to `GW` renamed instructions. It forwards at most `DW` of them as insert strobes toward the queues. Each lane's strobe carries the instruction's tag. When the queues push back or commit asks for a stall, the block parks the instructions that it cannot forward in a skid buffer. It then signals the rename stage with one-cycle block and unblock pulses. It also reports, every cycle, how many instruction slots it has retired from its input. Rename uses these credit counts to track its free queue entries.

The controller is a five-state machine:

- **Idle** is the state after reset. It behaves like Running, and it leaves for Running on the first cycle that forwards an instruction.
- **Running** forwards the incoming group directly.
- **Blocked** is entered on any stall, or when a group is wider than the dispatch width.
- **Unblocking** drains the skid buffer, oldest entries first. While it drains, new arrivals are queued behind the parked entries.
- **Squashing** is entered on a commit squash. It returns to Running on the first cycle that has neither a squash nor a stall.

A squash overrides everything else. It discards both the skid buffer and the incoming group. Every slot it discards is counted as credit.

The skid buffer holds `3*RDLY*GW + IW` entries. `RDLY` is the delay from rename to dispatch and `IW` is the issue width. This covers the instructions already in flight when the block pulse goes out.

Top module: `disp_stall_ctl`

## Requirements
- R1: After reset, the block is in Idle with an empty skid buffer. With no input, every insert strobe, `up_block`, `up_unblock` and `cred_vld` is low.
- R2: When `cmt_squash` is high, no insert strobe fires in that cycle. `cred_all` equals the skid occupancy plus the number of valid incoming lanes, and `cred_mem` counts the entries among them that carry the memory flag. The skid buffer is empty afterwards and the state becomes Squashing. `up_unblock` pulses only if the state was Blocked or Unblocking.
- R3: When there is no squash and any of `cmt_stall`, `iq_full`, `lsq_full` or `lsq_stall` is high, nothing is inserted. The valid incoming lanes are appended to the skid buffer in lane order and the state becomes Blocked. `up_block` pulses only if the state was neither Blocked nor Unblocking.
- R4: Valid incoming lanes are packed from lane 0. In Idle, Running or Squashing, at most `DW` lanes are forwarded, lane k of the input going to output lane k. If more than `DW` lanes are valid, the remaining lanes go to the skid buffer, `up_block` pulses, `up_unblock` stays low and the state becomes Blocked.
- R5: In Blocked or Unblocking with no squash and no stall, the oldest `min(occupancy, DW)` skid entries are forwarded in order. Incoming lanes are appended behind the remaining entries, and the state is Unblocking. If skid entries remained beyond `DW`, the state instead becomes Blocked with no new block pulse.
- R6: If a drain cycle leaves the skid buffer empty and brings no input, `up_unblock` pulses and the state becomes Running. `up_block` and `up_unblock` are never high together.
- R7: A forwarded slot whose squashed flag is set uses a dispatch lane but raises no insert strobe. Every forwarded slot adds one to `cred_all`, and one to `cred_mem` when its memory flag is set.
- R8: On a lane that forwards a live instruction, `iq_wr` is high. `lsq_wr` is also high when the memory flag is set, and `wr_tag` carries the instruction's tag. Lanes without a live instruction show a zero tag, and `lsq_wr` never fires without `iq_wr`.
- R9: In Squashing, a cycle with no squash and no stall forwards the incoming group directly and returns to Running. It does not raise `up_unblock`.
- R10: The skid buffer capacity is `3*RDLY*GW + IW` entries, and its occupancy never exceeds that capacity. A buffer filled to capacity drains in `ceil(capacity/DW)` cycles, and `up_unblock` pulses on the last of them.
- R11: The credit counts describe only the current cycle. `cred_vld` is high exactly in the cycles where `cred_all` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | GW | Incoming lane valid, packed from lane 0 |
| in_sq | input | GW | Incoming lane already squashed |
| in_mem | input | GW | Incoming lane is a load or store |
| in_tag | input | GW*TW | Incoming lane tags, lane k at bits k*TW |
| cmt_stall | input | 1 | Commit requests a stall |
| cmt_squash | input | 1 | Commit requests a squash |
| iq_full | input | 1 | Issue queue full |
| lsq_full | input | 1 | Load-store queue full |
| lsq_stall | input | 1 | Load-store queue stalled |
| iq_wr | output | DW | Issue-queue insert strobe per lane |
| lsq_wr | output | DW | Load-store-queue insert strobe per lane |
| wr_tag | output | DW*TW | Tag of the inserted instruction per lane |
| up_block | output | 1 | Block pulse toward rename |
| up_unblock | output | 1 | Unblock pulse toward rename |
| cred_vld | output | 1 | Credit bundle valid this cycle |
| cred_all | output | CW | Slots retired from the input this cycle |
| cred_mem | output | CW | Retired slots carrying the memory flag |

## Verification
The bench builds the block with a three-lane input group, a dispatch width of two, an issue width of two and a one-cycle rename delay, which gives an 11-entry skid buffer. Because the group is wider than the dispatch width, a full group overflows into the skid buffer on any cycle. Blocked-to-Unblocking oscillation, partial drains and a fill to exact capacity are therefore all reached within a few cycles. A long pseudo-random sweep covers every squash, stall, group-size and flag combination from every state. Each cycle's outputs are compared against a queue model built from the requirements.

// File: rtl/disp_stall_pkg.sv
package disp_stall_pkg;

    // Per-thread dispatch status
    typedef enum logic [2:0] {
        DS_IDLE = 3'd0,
        DS_RUN  = 3'd1,
        DS_BLK  = 3'd2,
        DS_UNB  = 3'd3,
        DS_SQ   = 3'd4
    } dsp_state_e;

    // What the current cycle does with its inputs
    typedef enum logic [1:0] {
        MD_PASS  = 2'd0,   // forward the incoming group
        MD_DRAIN = 2'd1,   // forward from the skid buffer
        MD_HOLD  = 2'd2,   // stall: park the incoming group
        MD_FLUSH = 2'd3    // squash: discard everything
    } dsp_mode_e;

endpackage

// File: rtl/disp_skid_fifo.sv
module disp_skid_fifo #(
    parameter int SK = 14,
    parameter int GW = 4,
    parameter int DW = 2,
    parameter int EW = 6,
    parameter int CW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CW-1:0]    pop_n,
    input  logic [CW-1:0]    push_n,
    input  logic [CW-1:0]    push_off,
    input  logic [GW*EW-1:0] push_ent,
    output logic [DW*EW-1:0] head_ent,
    output logic [CW-1:0]    cnt,
    output logic [CW-1:0]    mem_cnt
);

    logic [EW-1:0] mem_q [SK];
    logic [EW-1:0] nxt   [SK];
    logic [CW-1:0] cnt_q, nxt_cnt;
    int            base;

    // Entry 0 is always the oldest: pop shifts down, push appends.
    always_comb begin
        base = int'(cnt_q) - int'(pop_n);
        for (int i = 0; i < SK; i++) begin
            if (i + int'(pop_n) < SK) nxt[i] = mem_q[i + int'(pop_n)];
            else                      nxt[i] = '0;
        end
        for (int j = 0; j < GW; j++) begin
            if (j < int'(push_n) && base + j < SK && j + int'(push_off) < GW)
                nxt[base + j] = push_ent[(j + int'(push_off))*EW +: EW];
        end
        nxt_cnt = flush ? '0 : CW'(base + int'(push_n));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < SK; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= nxt_cnt;
            for (int i = 0; i < SK; i++) mem_q[i] <= nxt[i];
        end
    end

    always_comb begin
        mem_cnt = '0;
        for (int i = 0; i < SK; i++)
            if (i < int'(cnt_q)) mem_cnt = mem_cnt + CW'(mem_q[i][0]);
    end

    for (genvar k = 0; k < DW; k++) begin : g_head
        assign head_ent[k*EW +: EW] = mem_q[k];
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/disp_lane_issue.sv
module disp_lane_issue #(
    parameter int DW = 2,
    parameter int EW = 6,
    parameter int CW = 5
) (
    input  logic [DW*EW-1:0]     src_ent,
    input  logic [CW-1:0]        ndisp,
    input  logic [CW-1:0]        xtra_all,
    input  logic [CW-1:0]        xtra_mem,
    output logic [DW-1:0]        iq_wr,
    output logic [DW-1:0]        lsq_wr,
    output logic [DW*(EW-2)-1:0] wr_tag,
    output logic [CW-1:0]        cred_all,
    output logic [CW-1:0]        cred_mem,
    output logic                 cred_vld
);

    localparam int TW = EW - 2;

    // Entry layout: [0] memory flag, [1] squashed flag, [EW-1:2] tag
    always_comb begin
        cred_all = xtra_all;
        cred_mem = xtra_mem;
        iq_wr    = '0;
        lsq_wr   = '0;
        wr_tag   = '0;
        for (int k = 0; k < DW; k++) begin
            if (k < int'(ndisp)) begin
                cred_all = cred_all + CW'(1);
                cred_mem = cred_mem + CW'(src_ent[k*EW]);
                if (!src_ent[k*EW + 1]) begin
                    iq_wr[k]              = 1'b1;
                    lsq_wr[k]             = src_ent[k*EW];
                    wr_tag[k*TW +: TW]    = src_ent[k*EW + 2 +: TW];
                end
            end
        end
        cred_vld = (cred_all != '0);
    end

endmodule

// File: rtl/disp_stall_ctl.sv
module disp_stall_ctl
    import disp_stall_pkg::*;
#(
    parameter int GW   = 4,
    parameter int DW   = 2,
    parameter int IW   = 2,
    parameter int RDLY = 1,
    parameter int TW   = 4,
    localparam int EW  = TW + 2,
    localparam int SK  = 3 * (RDLY * GW) + IW,
    localparam int CW  = $clog2(SK + GW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GW-1:0]    in_vld,
    input  logic [GW-1:0]    in_sq,
    input  logic [GW-1:0]    in_mem,
    input  logic [GW*TW-1:0] in_tag,
    input  logic             cmt_stall,
    input  logic             cmt_squash,
    input  logic             iq_full,
    input  logic             lsq_full,
    input  logic             lsq_stall,
    output logic [DW-1:0]    iq_wr,
    output logic [DW-1:0]    lsq_wr,
    output logic [DW*TW-1:0] wr_tag,
    output logic             up_block,
    output logic             up_unblock,
    output logic             cred_vld,
    output logic [CW-1:0]    cred_all,
    output logic [CW-1:0]    cred_mem
);

    localparam logic [CW-1:0] DWC = CW'(DW);

    dsp_state_e st_q, st_d;
    dsp_mode_e  mode;

    logic             stall, was_held;
    logic [CW-1:0]    nin, in_mem_n, sk_cnt, sk_mem;
    logic [CW-1:0]    srccnt, ndisp, left, pop_n, push_n, push_off, sk_after;
    logic [CW-1:0]    xtra_all, xtra_mem;
    logic [GW*EW-1:0] in_ent;
    logic [DW*EW-1:0] sk_head, src_ent;

    for (genvar j = 0; j < GW; j++) begin : g_in
        assign in_ent[j*EW +: EW] = {in_tag[j*TW +: TW], in_sq[j], in_mem[j]};
    end

    always_comb begin
        nin      = '0;
        in_mem_n = '0;
        for (int j = 0; j < GW; j++) begin
            nin      = nin + CW'(in_vld[j]);
            in_mem_n = in_mem_n + CW'(in_vld[j] & in_mem[j]);
        end
    end

    // Stall sources in priority order; any one blocks
    assign stall    = cmt_stall | iq_full | lsq_full | lsq_stall;
    assign was_held = (st_q == DS_BLK) || (st_q == DS_UNB);

    always_comb begin
        if (cmt_squash)    mode = MD_FLUSH;
        else if (stall)    mode = MD_HOLD;
        else if (was_held) mode = MD_DRAIN;
        else               mode = MD_PASS;
    end

    always_comb begin
        srccnt   = (mode == MD_DRAIN) ? sk_cnt : (mode == MD_PASS) ? nin : '0;
        ndisp    = (srccnt > DWC) ? DWC : srccnt;
        left     = srccnt - ndisp;
        pop_n    = (mode == MD_DRAIN) ? ndisp : '0;
        push_n   = (mode == MD_PASS) ? left : (mode == MD_FLUSH) ? '0 : nin;
        push_off = (mode == MD_PASS) ? DWC : '0;
        sk_after = sk_cnt - pop_n + push_n;
        xtra_all = (mode == MD_FLUSH) ? sk_cnt + nin : '0;
        xtra_mem = (mode == MD_FLUSH) ? sk_mem + in_mem_n : '0;
    end

    for (genvar k = 0; k < DW; k++) begin : g_src
        if (k < GW) begin : g_both
            assign src_ent[k*EW +: EW] = (mode == MD_DRAIN) ? sk_head[k*EW +: EW]
                                                            : in_ent[k*EW +: EW];
        end else begin : g_skid
            assign src_ent[k*EW +: EW] = (mode == MD_DRAIN) ? sk_head[k*EW +: EW] : '0;
        end
    end

    disp_skid_fifo #(.SK(SK), .GW(GW), .DW(DW), .EW(EW), .CW(CW)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (mode == MD_FLUSH),
        .pop_n    (pop_n),
        .push_n   (push_n),
        .push_off (push_off),
        .push_ent (in_ent),
        .head_ent (sk_head),
        .cnt      (sk_cnt),
        .mem_cnt  (sk_mem)
    );

    disp_lane_issue #(.DW(DW), .EW(EW), .CW(CW)) u_lanes (
        .src_ent  (src_ent),
        .ndisp    (ndisp),
        .xtra_all (xtra_all),
        .xtra_mem (xtra_mem),
        .iq_wr    (iq_wr),
        .lsq_wr   (lsq_wr),
        .wr_tag   (wr_tag),
        .cred_all (cred_all),
        .cred_mem (cred_mem),
        .cred_vld (cred_vld)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (mode)
            MD_FLUSH: st_d = DS_SQ;
            MD_HOLD:  st_d = DS_BLK;
            MD_DRAIN: begin
                if (left != '0)          st_d = DS_BLK;
                else if (sk_after == '0) st_d = DS_RUN;
                else                     st_d = DS_UNB;
            end
            MD_PASS: begin
                if (left != '0)                          st_d = DS_BLK;
                else if (st_q == DS_IDLE && ndisp == '0) st_d = DS_IDLE;
                else                                     st_d = DS_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DS_IDLE;
        else        st_q <= st_d;
    end

    // Upstream handshake outputs
    always_comb begin
        up_block   = 1'b0;
        up_unblock = 1'b0;
        unique case (mode)
            MD_FLUSH: up_unblock = was_held;
            MD_HOLD:  up_block   = !was_held;
            MD_DRAIN: up_unblock = (left == '0) && (sk_after == '0);
            MD_PASS:  up_block   = (left != '0);
        endcase
    end

endmodule

// File: rtl/disp_stall_chk.sv
module disp_stall_chk
    import disp_stall_pkg::*;
#(
    parameter int DW = 2,
    parameter int CW = 5,
    parameter int SK = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmt_squash,
    input logic          cmt_stall,
    input logic          iq_full,
    input logic          lsq_full,
    input logic          lsq_stall,
    input logic [DW-1:0] iq_wr,
    input logic [DW-1:0] lsq_wr,
    input logic          up_block,
    input logic          up_unblock,
    input logic [CW-1:0] cred_all,
    input logic [CW-1:0] cred_mem,
    input logic [CW-1:0] sk_cnt,
    input dsp_state_e    st_q
);

    logic any_stall;
    assign any_stall = cmt_stall | iq_full | lsq_full | lsq_stall;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sk_cnt <= CW'(SK)); // R10
    AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |=> (sk_cnt == '0)); // R2
    AST_SQUASH_NO_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |-> (iq_wr == '0 && lsq_wr == '0)); // R2
    AST_STALL_NO_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_squash && any_stall) |-> (iq_wr == '0)); // R3
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_squash && any_stall) |=> (st_q == DS_BLK)); // R3
    AST_LSQ_NEEDS_IQ: assert property (@(posedge clk) disable iff (!rst_n)
        (lsq_wr & ~iq_wr) == '0); // R8
    AST_HANDSHAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_block && up_unblock)); // R6
    AST_UNBLOCK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_unblock && !cmt_squash) |=> (st_q == DS_RUN)); // R6
    AST_MEM_CREDIT_LE: assert property (@(posedge clk) disable iff (!rst_n)
        cred_mem <= cred_all); // R7

endmodule

bind disp_stall_ctl disp_stall_chk #(.DW(DW), .CW(CW), .SK(SK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmt_squash (cmt_squash),
    .cmt_stall  (cmt_stall),
    .iq_full    (iq_full),
    .lsq_full   (lsq_full),
    .lsq_stall  (lsq_stall),
    .iq_wr      (iq_wr),
    .lsq_wr     (lsq_wr),
    .up_block   (up_block),
    .up_unblock (up_unblock),
    .cred_all   (cred_all),
    .cred_mem   (cred_mem),
    .sk_cnt     (sk_cnt),
    .st_q       (st_q)
);

// File: tb/disp_stall_ctl_bench.sv
module disp_stall_ctl_bench;

    localparam int PER = 10;
    localparam int GW  = 3;
    localparam int DW  = 2;
    localparam int IW  = 2;
    localparam int RD  = 1;
    localparam int TW  = 4;
    localparam int SK  = 3 * (RD * GW) + IW;   // 11
    localparam int CW  = $clog2(SK + GW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [GW-1:0]    in_vld = '0, in_sq = '0, in_mem = '0;
    logic [GW*TW-1:0] in_tag = '0;
    logic cmt_stall = 1'b0, cmt_squash = 1'b0, iq_full = 1'b0, lsq_full = 1'b0, lsq_stall = 1'b0;
    logic [DW-1:0]    iq_wr, lsq_wr;
    logic [DW*TW-1:0] wr_tag;
    logic             up_block, up_unblock, cred_vld;
    logic [CW-1:0]    cred_all, cred_mem;

    always #(PER/2) clk = ~clk;

    disp_stall_ctl #(.GW(GW), .DW(DW), .IW(IW), .RDLY(RD), .TW(TW)) u_disp_stall_ctl (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sq(in_sq), .in_mem(in_mem),
        .in_tag(in_tag), .cmt_stall(cmt_stall), .cmt_squash(cmt_squash),
        .iq_full(iq_full), .lsq_full(lsq_full), .lsq_stall(lsq_stall),
        .iq_wr(iq_wr), .lsq_wr(lsq_wr), .wr_tag(wr_tag), .up_block(up_block),
        .up_unblock(up_unblock), .cred_vld(cred_vld), .cred_all(cred_all),
        .cred_mem(cred_mem)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // Requirement-level model: state code 0 Idle, 1 Running, 2 Blocked, 3 Unblocking, 4 Squashing
    int         mst = 0;
    logic [5:0] mq [$];          // {tag, squashed, mem}
    logic [3:0] tagc = 4'd0;
    logic       s_unbl;
    logic       s_blk;
    logic [DW-1:0] s_iq;

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_cycle(input logic sqsh, input logic [3:0] stl, input int n,
                             input logic [2:0] sqf, input logic [2:0] memf);
        logic [5:0] inc [3];
        logic [5:0] src [2];
        int nd, sb, e_all, e_mem;
        logic e_blk, e_unb, held;
        logic [DW-1:0] e_iq, e_lsq;
        logic [DW*TW-1:0] e_tag;
        logic [GW-1:0] vmask;
        vmask = '0;
        for (int j = 0; j < GW; j++) begin
            inc[j] = {tagc, sqf[j], memf[j]};
            if (j < n) begin
                vmask[j] = 1'b1;
                tagc = tagc + 4'd1;
            end
        end
        in_vld = vmask;
        in_sq  = sqf;
        in_mem = memf;
        in_tag = {inc[2][5:2], inc[1][5:2], inc[0][5:2]};
        cmt_squash = sqsh;
        {lsq_stall, lsq_full, iq_full, cmt_stall} = stl;

        e_all = 0; e_mem = 0; e_blk = 0; e_unb = 0; nd = 0;
        e_iq = '0; e_lsq = '0; e_tag = '0;
        src[0] = '0; src[1] = '0;
        held = (mst == 2 || mst == 3);
        if (sqsh) begin
            e_all = mq.size() + n;
            foreach (mq[i]) e_mem += int'(mq[i][0]);
            for (int j = 0; j < n; j++) e_mem += int'(inc[j][0]);
            e_unb = held;
            mq.delete();
            mst = 4;
        end else if (stl != 4'd0) begin
            for (int j = 0; j < n; j++) mq.push_back(inc[j]);
            e_blk = !held;
            mst = 2;
        end else if (held) begin
            sb = mq.size();
            nd = (sb > DW) ? DW : sb;
            for (int k = 0; k < nd; k++) src[k] = mq.pop_front();
            for (int j = 0; j < n; j++) mq.push_back(inc[j]);
            if (sb > DW) mst = 2;
            else if (mq.size() == 0) begin e_unb = 1; mst = 1; end
            else mst = 3;
        end else begin
            nd = (n > DW) ? DW : n;
            for (int k = 0; k < nd; k++) src[k] = inc[k];
            if (n > DW) begin
                for (int j = DW; j < n; j++) mq.push_back(inc[j]);
                e_blk = 1;
                mst = 2;
            end else if (!(mst == 0 && nd == 0)) mst = 1;
        end
        for (int k = 0; k < nd; k++) begin
            e_all++;
            e_mem += int'(src[k][0]);
            if (!src[k][1]) begin
                e_iq[k] = 1'b1;
                e_lsq[k] = src[k][0];
                e_tag[k*TW +: TW] = src[k][5:2];
            end
        end

        #(PER/2);
        chk("R4",  "iq_wr",      int'(iq_wr),      int'(e_iq));
        chk("R8",  "lsq_wr",     int'(lsq_wr),     int'(e_lsq));
        chk("R5",  "wr_tag",     int'(wr_tag),     int'(e_tag));
        chk("R3",  "up_block",   int'(up_block),   int'(e_blk));
        chk("R6",  "up_unblock", int'(up_unblock), int'(e_unb));
        chk("R7",  "cred_all",   int'(cred_all),   e_all);
        chk("R2",  "cred_mem",   int'(cred_mem),   e_mem);
        chk("R11", "cred_vld",   int'(cred_vld),   int'(e_all != 0));
        s_unbl = up_unblock;
        s_blk  = up_block;
        s_iq   = iq_wr;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(PER * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        int drains;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #(PER/2);
        // R1: reset state, no activity
        chk("R1", "iq_wr",      int'(iq_wr),      0);
        chk("R1", "up_block",   int'(up_block),   0);
        chk("R1", "up_unblock", int'(up_unblock), 0);
        chk("R1", "cred_vld",   int'(cred_vld),   0);
        @(posedge clk); #1;

        // Plain pass with a load and a squashed lane
        run_cycle(1'b0, 4'd0, 2, 3'b010, 3'b001);
        run_cycle(1'b0, 4'd0, 2, 3'b000, 3'b011);
        // Overflow by dispatch width (R4), then fill the skid to capacity
        run_cycle(1'b0, 4'd0, 3, 3'b000, 3'b100);
        run_cycle(1'b0, 4'b0001, 3, 3'b000, 3'b000);
        run_cycle(1'b0, 4'b0010, 3, 3'b001, 3'b010);
        run_cycle(1'b0, 4'b0100, 3, 3'b000, 3'b101);
        run_cycle(1'b0, 4'b1000, 1, 3'b000, 3'b000);
        chk("R10", "skid filled to capacity", mq.size(), SK);
        // Drain: ceil(11/2) = 6 cycles until the unblock pulse
        drains = 0;
        s_unbl = 1'b0;
        while (!s_unbl && drains < 12) begin
            run_cycle(1'b0, 4'd0, 0, 3'b000, 3'b000);
            drains++;
        end
        chk("R10", "drain cycles to unblock", drains, (SK + DW - 1) / DW);

        // Squash while blocked, then recover (R9)
        run_cycle(1'b0, 4'b0001, 2, 3'b000, 3'b011);
        run_cycle(1'b1, 4'd0, 3, 3'b000, 3'b111);
        run_cycle(1'b0, 4'd0, 2, 3'b000, 3'b000);
        chk("R9", "direct insert after squash", int'(s_iq), 3);
        chk("R9", "no unblock on recovery", int'(s_unbl), 0);
        run_cycle(1'b0, 4'd0, 1, 3'b000, 3'b000);
        chk("R9", "back in running, no block", int'(s_blk), 0);

        // Sweep over squash, stall sources, group sizes and flags
        lf = 16'hACE1;
        for (int c = 0; c < 4000; c++) begin
            logic sq;
            logic [3:0] st;
            int n;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            sq = (lf[3:0] == 4'd0);
            unique case (lf[7:4])
                4'd1: st = 4'b0001;
                4'd2: st = 4'b0010;
                4'd3: st = 4'b0100;
                4'd4: st = 4'b1000;
                4'd5: st = 4'b0110;
                default: st = 4'b0000;
            endcase
            n = int'(lf[9:8]);
            if (mq.size() + n > SK) n = 0;
            run_cycle(sq, st, n, lf[12:10], lf[15:13]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule